// File: doc/BRIEF.md
# Ceiling Float-to-Unsigned Converter

This block takes one IEEE 754 operand in half, single or double precision and turns it into an unsigned integer of 32 or 64 bits. The rounding rule is fixed: every conversion rounds toward plus infinity. Values that cannot be represented saturate, and invalid and inexact flags report what happened. Half and single operands occupy the low bits of a 64-bit operand bus, and the upper bits are ignored.

A caller presents the operand, a 2-bit format code and a width select together with a one-cycle valid strobe. One clock later the result, its valid strobe and the flags appear on registered outputs. These outputs hold their values until the next strobe. A 32-bit result is zero-extended to 64 bits. The reserved format code produces no conversion and is reported on a separate illegal-format output.

Top module: `ceil_f2u`

## Requirements
- R1: The format code selects the source: 2'b11 is half precision (bits 15:0), 2'b00 is single (bits 31:0) and 2'b01 is double (bits 63:0). Operand bits above the selected format have no effect on the result.
- R2: Format code 2'b10 gives a result of 0 with out_illegal high and both out_invalid and out_inexact low. Every other code gives out_illegal low.
- R3: in_wide = 0 selects a 32-bit result, with bits 63:32 of out_result zero. in_wide = 1 selects a 64-bit result.
- R4: A positive finite input whose fraction is nonzero yields its integer part plus one and raises out_inexact, unless it saturates.
- R5: A positive input with an exact integer value yields that value with no flag raised. Positive zero yields 0 with no flag.
- R6: Positive infinity, and any positive value whose rounded result does not fit the selected width, yield all ones of that width (0xFFFFFFFF or 0xFFFFFFFFFFFFFFFF) with out_invalid high and out_inexact low.
- R7: A NaN input yields 0 with out_invalid high.
- R8: A negative input in (-1, 0) yields 0 with only out_inexact. Negative inputs of -1 or below, including negative infinity, yield 0 with only out_invalid. Negative zero yields 0 with no flag.
- R9: Subnormal inputs convert by their true value. A positive subnormal yields 1 with out_inexact.
- R10: out_valid is high exactly in the cycle after each in_valid cycle. Results and flags change only on a strobe. out_invalid and out_inexact are never high together.
- R11: After reset, out_valid, out_result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| in_fmt | input | 2 | Source format code |
| in_wide | input | 1 | Result width select (0: 32-bit, 1: 64-bit) |
| in_operand | input | 64 | Floating-point operand, low-aligned |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Unsigned integer result |
| out_illegal | output | 1 | Reserved format code was used |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
On every cycle the assertions check the following:
- the one-cycle strobe relation, and that outputs stay stable between strobes;
- that invalid and inexact are never raised together;
- the reserved-code behaviour and the zero upper half of narrow results;
- that any nonzero invalid result is the all-ones pattern of the width that was requested.

Only the directed scenarios can show that the numeric results are correct. These cover rounding up of fractions, exact conversion, saturation on both sides of each width boundary, NaN and infinities, the three negative ranges and subnormals. They cover each of the three source formats, and they show that high operand bits are ignored for narrow formats.

// File: rtl/ceil_f2u_pkg.sv
package ceil_f2u_pkg;
  localparam int INT_W    = 64;
  localparam int NARROW_W = 32;
  localparam int SIG_W    = 53;
  localparam int EXP_W    = 13;
  localparam int NUM_FMT  = 3;

  // Slot order: half, single, double
  localparam int FMT_EXP [NUM_FMT] = '{5, 8, 11};
  localparam int FMT_MAN [NUM_FMT] = '{10, 23, 52};

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_RSVD   = 2'b10,
    FMT_HALF   = 2'b11
  } fmt_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_zero;
    logic                    is_inf;
    logic                    is_nan;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unp_t;
endpackage

// File: rtl/ceil_f2u_field.sv
module ceil_f2u_field
  import ceil_f2u_pkg::*;
#(
  parameter int E_BITS = 8,
  parameter int M_BITS = 23,
  localparam int SRC_W = 1 + E_BITS + M_BITS
) (
  input  logic [SRC_W-1:0] src_i,
  output unp_t             unp_o
);
  localparam int BIAS = (1 << (E_BITS - 1)) - 1;
  localparam int SIG_PAD = SIG_W - 1 - M_BITS;

  logic [E_BITS-1:0] efield;
  logic [M_BITS-1:0] mfield;
  logic              e_zero;
  logic              e_ones;
  logic              m_zero;

  assign efield = src_i[SRC_W-2 -: E_BITS];
  assign mfield = src_i[M_BITS-1:0];
  assign e_zero = (efield == '0);
  assign e_ones = (efield == '1);
  assign m_zero = (mfield == '0);

  always_comb begin
    unp_o.sign    = src_i[SRC_W-1];
    unp_o.is_zero = e_zero & m_zero;
    unp_o.is_inf  = e_ones & m_zero;
    unp_o.is_nan  = e_ones & ~m_zero;
    // subnormals use the minimum exponent with no hidden bit
    if (e_zero) begin
      unp_o.exp = EXP_W'(1 - BIAS);
    end else begin
      unp_o.exp = EXP_W'(efield) - EXP_W'(BIAS);
    end
    unp_o.sig = SIG_W'({~e_zero, mfield}) << SIG_PAD;
  end
endmodule

// File: rtl/ceil_f2u_align.sv
module ceil_f2u_align
  import ceil_f2u_pkg::*;
(
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic [INT_W-1:0]        int_o,
  output logic                    frac_nz_o,
  output logic                    huge_o,
  output logic                    below_one_o
);
  localparam int WIDE_W = SIG_W + INT_W - 1;
  localparam int SH_W   = $clog2(INT_W);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  logic [WIDE_W-1:0] wide;

  assign below_one_o = (exp_i < 0);
  assign huge_o      = (exp_i >= EXP_LIM);
  assign wide        = WIDE_W'(sig_i) << exp_i[SH_W-1:0];

  always_comb begin
    if (below_one_o) begin
      int_o     = '0;
      frac_nz_o = |sig_i;
    end else if (huge_o) begin
      int_o     = '0;
      frac_nz_o = 1'b0;
    end else begin
      int_o     = wide[WIDE_W-1:SIG_W-1];
      frac_nz_o = |wide[SIG_W-2:0];
    end
  end
endmodule

// File: rtl/ceil_f2u_round.sv
module ceil_f2u_round
  import ceil_f2u_pkg::*;
(
  input  logic             sign_i,
  input  logic             is_zero_i,
  input  logic             is_inf_i,
  input  logic             is_nan_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             frac_nz_i,
  input  logic             huge_i,
  input  logic             below_one_i,
  input  logic             wide_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  logic [INT_W:0]   sum;
  logic [INT_W-1:0] sat;
  logic             ovf;

  assign sum = {1'b0, int_i} + (INT_W+1)'(frac_nz_i);
  assign sat = wide_i ? {INT_W{1'b1}} : INT_W'({NARROW_W{1'b1}});
  assign ovf = huge_i | (wide_i ? sum[INT_W] : (|sum[INT_W:NARROW_W]));

  always_comb begin
    res_o     = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (is_nan_i) begin
      invalid_o = 1'b1;
    end else if (is_inf_i) begin
      res_o     = sign_i ? '0 : sat;
      invalid_o = 1'b1;
    end else if (is_zero_i) begin
      res_o = '0;
    end else if (sign_i) begin
      // toward plus infinity: (-1,0) rounds up to zero
      if (below_one_i) inexact_o = 1'b1;
      else             invalid_o = 1'b1;
    end else if (ovf) begin
      res_o     = sat;
      invalid_o = 1'b1;
    end else begin
      res_o     = sum[INT_W-1:0];
      inexact_o = frac_nz_i;
    end
  end
endmodule

// File: rtl/ceil_f2u.sv
module ceil_f2u
  import ceil_f2u_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_fmt,
  input  logic             in_wide,
  input  logic [INT_W-1:0] in_operand,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_illegal,
  output logic             out_invalid,
  output logic             out_inexact
);
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  unp_t unp_arr [NUM_FMT];
  unp_t unp_sel;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EB = FMT_EXP[g];
    localparam int MB = FMT_MAN[g];
    ceil_f2u_field #(.E_BITS(EB), .M_BITS(MB)) u_field (
      .src_i (in_operand[EB+MB:0]),
      .unp_o (unp_arr[g])
    );
  end

  logic is_rsvd;

  always_comb begin
    is_rsvd = 1'b0;
    unp_sel = unp_arr[1];
    case (fmt_e'(in_fmt))
      FMT_HALF:   unp_sel = unp_arr[0];
      FMT_SINGLE: unp_sel = unp_arr[1];
      FMT_DOUBLE: unp_sel = unp_arr[2];
      default:    is_rsvd = 1'b1;
    endcase
  end

  logic [INT_W-1:0] int_part;
  logic             frac_nz;
  logic             huge;
  logic             below_one;

  ceil_f2u_align u_align (
    .exp_i       (unp_sel.exp),
    .sig_i       (unp_sel.sig),
    .int_o       (int_part),
    .frac_nz_o   (frac_nz),
    .huge_o      (huge),
    .below_one_o (below_one)
  );

  logic [INT_W-1:0] conv_res;
  logic             conv_inv;
  logic             conv_inx;

  ceil_f2u_round u_round (
    .sign_i      (unp_sel.sign),
    .is_zero_i   (unp_sel.is_zero),
    .is_inf_i    (unp_sel.is_inf),
    .is_nan_i    (unp_sel.is_nan),
    .int_i       (int_part),
    .frac_nz_i   (frac_nz),
    .huge_i      (huge),
    .below_one_i (below_one),
    .wide_i      (in_wide),
    .res_o       (conv_res),
    .invalid_o   (conv_inv),
    .inexact_o   (conv_inx)
  );

  logic [INT_W-1:0] nxt_result;
  logic             nxt_invalid;
  logic             nxt_inexact;

  always_comb begin
    if (is_rsvd) begin
      nxt_result  = '0;
      nxt_invalid = 1'b0;
      nxt_inexact = 1'b0;
    end else begin
      nxt_result  = conv_res;
      nxt_invalid = conv_inv;
      nxt_inexact = conv_inx;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_illegal <= is_rsvd;
        out_invalid <= nxt_invalid;
        out_inexact <= nxt_inexact;
      end
    end
  end
endmodule

// File: rtl/ceil_f2u_chk.sv
module ceil_f2u_chk
  import ceil_f2u_pkg::*;
(
  input logic             clk,
  input logic             rst_q_n,
  input logic             in_valid,
  input logic [1:0]       in_fmt,
  input logic             in_wide,
  input logic             out_valid,
  input logic [INT_W-1:0] out_result,
  input logic             out_illegal,
  input logic             out_invalid,
  input logic             out_inexact
);
  localparam logic [INT_W-1:0] ALL_W = {INT_W{1'b1}};
  localparam logic [INT_W-1:0] ALL_N = INT_W'({NARROW_W{1'b1}});

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_result) && $stable(out_invalid) && $stable(out_inexact)));

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> !(out_invalid && out_inexact));

  assert_illegal_track_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (out_illegal == ($past(in_fmt) == 2'b10)));

  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && out_illegal) |-> (out_result == '0 && !out_invalid && !out_inexact));

  assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !in_wide) |=> (out_result[INT_W-1:NARROW_W] == '0));

  assert_sat_pattern_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (!(out_invalid && out_result != '0) ||
                  out_result == ($past(in_wide) ? ALL_W : ALL_N)));
endmodule

bind ceil_f2u ceil_f2u_chk chk_i (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .in_valid    (in_valid),
  .in_fmt      (in_fmt),
  .in_wide     (in_wide),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/ceil_f2u_tb_top.sv
module ceil_f2u_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_fmt;
  logic        in_wide;
  logic [63:0] in_operand;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_illegal;
  logic        out_invalid;
  logic        out_inexact;

  int checks;
  int failures;
  bit done;

  localparam logic [1:0] F_S = 2'b00, F_D = 2'b01, F_R = 2'b10, F_H = 2'b11;

  ceil_f2u dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_wide(in_wide), .in_operand(in_operand), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_out(input string req, input logic [63:0] er,
                           input logic ei, input logic ex, input logic il);
    checks++;
    if (out_valid !== 1'b1 || out_result !== er || out_invalid !== ei ||
        out_inexact !== ex || out_illegal !== il) begin
      failures++;
      $display("FAIL %s actual v=%0b res=%h inv=%0b inx=%0b ill=%0b expected v=1 res=%h inv=%0b inx=%0b ill=%0b",
               req, out_valid, out_result, out_invalid, out_inexact, out_illegal, er, ei, ex, il);
    end
  endtask

  task automatic conv(input string req, input logic [1:0] f, input logic w,
                      input logic [63:0] op, input logic [63:0] er,
                      input logic ei, input logic ex, input logic il);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_wide = w; in_operand = op;
    @(negedge clk);
    in_valid = 1'b0; in_operand = 64'hA5A5_5A5A_A5A5_5A5A;
    check_out(req, er, ei, ex, il);
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || out_result !== 64'd0 || out_invalid !== 1'b0 ||
        out_inexact !== 1'b0 || out_illegal !== 1'b0) begin
      failures++;
      $display("FAIL R11 actual v=%0b res=%h expected v=0 res=0 flags=0", out_valid, out_result);
    end
  endtask

  task automatic t_formats;
    conv("R1 single", F_S, 1'b1, 64'h0000_0000_3FC0_0000, 64'd2, 0, 1, 0);
    conv("R1 double", F_D, 1'b1, 64'h4000_0000_0000_0000, 64'd2, 0, 0, 0);
    conv("R1 half",   F_H, 1'b0, 64'h0000_0000_0000_4280, 64'd4, 0, 1, 0);
    conv("R1 half high bits ignored", F_H, 1'b0, 64'hDEAD_BEEF_1234_4280, 64'd4, 0, 1, 0);
    conv("R1 single high bits ignored", F_S, 1'b1, 64'hFFFF_FFFF_3FC0_0000, 64'd2, 0, 1, 0);
  endtask

  task automatic t_illegal;
    conv("R2 reserved code", F_R, 1'b1, 64'h0000_0000_3FC0_0000, 64'd0, 0, 0, 1);
    conv("R2 reserved code nan", F_R, 1'b0, 64'h7FF8_0000_0000_0000, 64'd0, 0, 0, 1);
  endtask

  task automatic t_round_exact;
    conv("R4 quarter", F_D, 1'b1, 64'h3FD0_0000_0000_0000, 64'd1, 0, 1, 0);
    conv("R4 near 2^32 wide", F_D, 1'b1, 64'h41EF_FFFF_FFF0_0000, 64'h1_0000_0000, 0, 1, 0);
    conv("R5 half max", F_H, 1'b0, 64'h0000_0000_0000_7BFF, 64'd65504, 0, 0, 0);
    conv("R5 single below 2^32", F_S, 1'b0, 64'h0000_0000_4F7F_FFFF, 64'hFFFF_FF00, 0, 0, 0);
    conv("R5 double max below 2^64", F_D, 1'b1, 64'h43EF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_F800, 0, 0, 0);
    conv("R5 plus zero", F_S, 1'b0, 64'h0, 64'd0, 0, 0, 0);
  endtask

  task automatic t_width_sat;
    conv("R3 R6 2^32 narrow", F_S, 1'b0, 64'h0000_0000_4F80_0000, 64'h0000_0000_FFFF_FFFF, 1, 0, 0);
    conv("R3 2^32 wide", F_S, 1'b1, 64'h0000_0000_4F80_0000, 64'h0000_0001_0000_0000, 0, 0, 0);
    conv("R6 round carries past 32", F_D, 1'b0, 64'h41EF_FFFF_FFF0_0000, 64'h0000_0000_FFFF_FFFF, 1, 0, 0);
    conv("R6 2^64 wide", F_D, 1'b1, 64'h43F0_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    conv("R6 plus inf wide", F_S, 1'b1, 64'h0000_0000_7F80_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    conv("R6 plus inf narrow", F_H, 1'b0, 64'h0000_0000_0000_7C00, 64'h0000_0000_FFFF_FFFF, 1, 0, 0);
  endtask

  task automatic t_special;
    conv("R7 double nan", F_D, 1'b1, 64'h7FF8_0000_0000_0000, 64'd0, 1, 0, 0);
    conv("R7 half nan", F_H, 1'b0, 64'h0000_0000_0000_7E01, 64'd0, 1, 0, 0);
    conv("R8 minus half", F_S, 1'b1, 64'h0000_0000_BF00_0000, 64'd0, 0, 1, 0);
    conv("R8 minus one", F_S, 1'b1, 64'h0000_0000_BF80_0000, 64'd0, 1, 0, 0);
    conv("R8 minus zero", F_H, 1'b1, 64'h0000_0000_0000_8000, 64'd0, 0, 0, 0);
    conv("R8 minus inf", F_H, 1'b0, 64'h0000_0000_0000_FC00, 64'd0, 1, 0, 0);
    conv("R9 single subnormal", F_S, 1'b0, 64'h0000_0000_0000_0001, 64'd1, 0, 1, 0);
    conv("R9 double subnormal", F_D, 1'b1, 64'h0000_0000_0000_0001, 64'd1, 0, 1, 0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; in_fmt = F_D; in_wide = 1'b1; in_operand = 64'h4000_0000_0000_0000;
    @(negedge clk);
    check_out("R10 back-to-back first", 64'd2, 0, 0, 0);
    in_fmt = F_S; in_wide = 1'b1; in_operand = 64'h0000_0000_BF80_0000;
    @(negedge clk);
    check_out("R10 back-to-back second", 64'd0, 1, 0, 0);
    in_valid = 1'b0; in_fmt = F_H; in_operand = 64'h0000_0000_0000_7BFF;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 64'd0 || out_invalid !== 1'b1) begin
      failures++;
      $display("FAIL R10 idle actual v=%0b res=%h inv=%0b expected v=0 res=0 inv=1",
               out_valid, out_result, out_invalid);
    end
  endtask

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_fmt = 2'b00; in_wide = 1'b0; in_operand = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_formats();
    t_illegal();
    t_round_exact();
    t_width_sat();
    t_special();
    t_stream();
    done = 1'b1;
    report();
    $finish;
  end
endmodule